// File: doc/BRIEF.md
# Clock PLL Bring-Up Sequencer

This block performs the power-up sequence for a clock-control register that drives two receive and two transmit PLL pairs. A single-cycle start pulse launches it. At that moment the current register contents are captured once from a read port, together with the receive and transmit width modes and four 2-bit frequency multipliers. The block then issues four read-modify-write updates in four consecutive cycles on a single-cycle write strobe. These updates put the PLLs in powerdown and bypass, program the clocking mode and multipliers, release bypass, and finally release powerdown.

A direction (receive or transmit) runs in dual-clock mode whenever its width mode is anything other than a single 32-bit lane. Dual mode widens the set of bypass and powerdown bits that the last two updates clear. After the final update, a blind down-counter waits out the lock time and then pulses a done flag. No lock status is consulted. The lock time is the clock frequency in MHz times the lock delay in microseconds, both given as parameters.

Top module: `pll_bringup_seq`

## Requirements
- R1: While reset is held and immediately after it, `busy_o`, `done_o` and `wr_en_o` are low.
- R2: A start pulse accepted while idle causes a write in the next cycle to address `CTRL_ADDR`, with data equal to the `rd_data_i` value present at the start edge, ORed with 0x0000F0F0.
- R3: A direction is in dual mode exactly when its width-mode input is nonzero at the start edge (code 0 means a single 32-bit lane). The receive and transmit flags are chosen independently.
- R4: The second write equals the first, except in two fields. Bit 24 holds the receive dual flag and bit 25 holds the transmit dual flag. Bits 23:16 hold the multipliers: receive pair 0/1 at 17:16, receive pair 2/3 at 19:18, transmit pair 0/1 at 21:20, transmit pair 2/3 at 23:22.
- R5: The third write equals the second with bits 12 and 14 cleared. Bit 13 is also cleared when receive is dual, and bit 15 is also cleared when transmit is dual.
- R6: The fourth write equals the third with bits 4 and 6 cleared. Bit 5 is also cleared when receive is dual, and bit 7 is also cleared when transmit is dual.
- R7: The write strobe is high in exactly four consecutive cycles per sequence and never at any other time.
- R8: If the fourth write occurs in cycle k, `done_o` is high in cycle k+LOCK_CYCLES and in no other cycle of that sequence.
- R9: A start pulse while busy is ignored, together with any change of `rd_data_i` after the start edge. The write data, write count and done timing are unchanged.
- R10: `busy_o` is high from the cycle after the accepted start up to and including the cycle before `done_o`, and low while `done_o` is high. A new start is accepted in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| rx_width_i | input | MODE_W | Receive width mode; 0 = single 32-bit lane |
| tx_width_i | input | MODE_W | Transmit width mode; 0 = single 32-bit lane |
| rx_mul_lo_i | input | MUL_W | Receive pair 0/1 multiplier |
| rx_mul_hi_i | input | MUL_W | Receive pair 2/3 multiplier |
| tx_mul_lo_i | input | MUL_W | Transmit pair 0/1 multiplier |
| tx_mul_hi_i | input | MUL_W | Transmit pair 2/3 multiplier |
| rd_data_i | input | 32 | Current clock-control register contents |
| wr_en_o | output | 1 | Single-cycle register write strobe |
| wr_addr_o | output | ADDR_W | Write address (always CTRL_ADDR) |
| wr_data_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check several properties. Writes occur only while busy, and busy and done never overlap. Done lasts a single cycle, and busy only falls into a done cycle. The first write always carries the powerdown and bypass bits. No write appears during the wait phase, even when start is pulsed. The lock counter steps down by one and stops at zero. Other properties need the bench's scenarios. The exact data of each of the four writes for every combination of dual flags and multipliers is one of them. Another is capture of the read value only at the start edge. The done cycle at exactly LOCK_CYCLES after the last write, and a restart accepted in the done cycle, are shown only there as well.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   localparam int unsigned REG_W = 32;

   // bit layout of the clock-control register
   localparam logic [REG_W-1:0] PD_BYP_SET  = 32'h0000_F0F0;
   localparam logic [REG_W-1:0] BYP_ALWAYS  = 32'h0000_5000;
   localparam logic [REG_W-1:0] PD_ALWAYS   = 32'h0000_0050;
   localparam int unsigned      BYP_RX_BIT  = 13;
   localparam int unsigned      BYP_TX_BIT  = 15;
   localparam int unsigned      PD_RX_BIT   = 5;
   localparam int unsigned      PD_TX_BIT   = 7;
   localparam int unsigned      MUL_LSB     = 16;
   localparam int unsigned      DUAL_RX_BIT = 24;
   localparam int unsigned      DUAL_TX_BIT = 25;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWRDN,
      ST_MODE,
      ST_BYPOFF,
      ST_PWRON,
      ST_WAIT
   } seq_state_t;

   typedef struct packed {
      logic tx_dual;
      logic rx_dual;
   } dual_cfg_t;

endpackage

// File: rtl/pll_step_word.sv
module pll_step_word
   import pll_seq_pkg::*;
#(
   parameter int unsigned MUL_W     = 2,
   parameter int unsigned NUM_PAIRS = 4
) (
   input  seq_state_t                    step_i,
   input  logic [REG_W-1:0]              base_i,
   input  dual_cfg_t                     cfg_i,
   input  logic [NUM_PAIRS*MUL_W-1:0]    mul_i,
   output logic [REG_W-1:0]              word_o
);

   localparam int unsigned FIELD_W = NUM_PAIRS * MUL_W;
   localparam logic [REG_W-1:0] MUL_MASK =
      REG_W'(((64'd1 << FIELD_W) - 64'd1) << MUL_LSB);
   localparam logic [REG_W-1:0] DUAL_MASK =
      (REG_W'(1) << DUAL_RX_BIT) | (REG_W'(1) << DUAL_TX_BIT);

   initial begin
      if (MUL_W < 1) $error("MUL_W must be at least 1");
      if (MUL_LSB + FIELD_W > DUAL_RX_BIT)
         $error("multiplier field overlaps the dual-clock bits");
   end

   logic [REG_W-1:0] fld [NUM_PAIRS];
   logic [REG_W-1:0] mul_word;

   for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_mul_place
      assign fld[g] = REG_W'(mul_i[g*MUL_W +: MUL_W]) << (MUL_LSB + g*MUL_W);
   end

   always_comb begin
      mul_word = '0;
      for (int i = 0; i < NUM_PAIRS; i++) mul_word = mul_word | fld[i];
   end

   logic [REG_W-1:0] dual_word, byp_clr, pd_clr;
   assign dual_word = (REG_W'(cfg_i.rx_dual) << DUAL_RX_BIT)
                    | (REG_W'(cfg_i.tx_dual) << DUAL_TX_BIT);
   assign byp_clr   = BYP_ALWAYS | (REG_W'(cfg_i.rx_dual) << BYP_RX_BIT)
                    | (REG_W'(cfg_i.tx_dual) << BYP_TX_BIT);
   assign pd_clr    = PD_ALWAYS | (REG_W'(cfg_i.rx_dual) << PD_RX_BIT)
                    | (REG_W'(cfg_i.tx_dual) << PD_TX_BIT);

   always_comb begin
      unique case (step_i)
         ST_PWRDN:  word_o = base_i | PD_BYP_SET;
         ST_MODE:   word_o = (base_i & ~(MUL_MASK | DUAL_MASK)) | mul_word | dual_word;
         ST_BYPOFF: word_o = base_i & ~byp_clr;
         ST_PWRON:  word_o = base_i & ~pd_clr;
         default:   word_o = base_i;
      endcase
   end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int unsigned CYCLES = 20000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   output logic expired_o
);

   localparam int unsigned CW = $clog2(CYCLES + 1);

   initial begin
      if (CYCLES < 1) $error("CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= CW'(CYCLES - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = run_q && (cnt_q == '0);

   // R8: the wait counts down one per cycle and stops at zero
   p_count_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
   p_stop_at_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expired_o && !load_i) |=> !run_q);

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
   import pll_seq_pkg::*;
#(
   parameter int unsigned MODE_W    = 2,
   parameter int unsigned MUL_W     = 2,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned CLK_MHZ   = 200,
   parameter int unsigned LOCK_US   = 100
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [MODE_W-1:0] rx_width_i,
   input  logic [MODE_W-1:0] tx_width_i,
   input  logic [MUL_W-1:0]  rx_mul_lo_i,
   input  logic [MUL_W-1:0]  rx_mul_hi_i,
   input  logic [MUL_W-1:0]  tx_mul_lo_i,
   input  logic [MUL_W-1:0]  tx_mul_hi_i,
   input  logic [31:0]       rd_data_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [31:0]       wr_data_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int unsigned NUM_PAIRS   = 4;
   localparam int unsigned LOCK_CYCLES = CLK_MHZ * LOCK_US;

   initial begin
      if (MODE_W < 1)   $error("MODE_W must be at least 1");
      if (LOCK_CYCLES < 1) $error("lock time must be at least one cycle");
      if (CTRL_ADDR >= (1 << ADDR_W)) $error("CTRL_ADDR does not fit ADDR_W");
   end

   seq_state_t                     state_q, step;
   dual_cfg_t                      cfg_q, cfg_in, cfg_sel;
   logic [NUM_PAIRS*MUL_W-1:0]     mul_q, mul_in, mul_sel;
   logic [31:0]                    base_sel, word;
   logic                           wr_en_q, busy_q, done_q, expired;
   logic [31:0]                    wr_data_q;
   logic                           idle, accept;

   // R3: any width mode other than the single wide lane selects dual clocks
   assign cfg_in.rx_dual = |rx_width_i;
   assign cfg_in.tx_dual = |tx_width_i;
   assign mul_in         = {tx_mul_hi_i, tx_mul_lo_i, rx_mul_hi_i, rx_mul_lo_i};

   assign idle   = (state_q == ST_IDLE);
   assign accept = idle && start_i;

   always_comb begin
      unique case (state_q)
         ST_IDLE:   step = ST_PWRDN;
         ST_PWRDN:  step = ST_MODE;
         ST_MODE:   step = ST_BYPOFF;
         ST_BYPOFF: step = ST_PWRON;
         default:   step = ST_IDLE;
      endcase
   end

   assign base_sel = idle ? rd_data_i : wr_data_q;
   assign cfg_sel  = idle ? cfg_in    : cfg_q;
   assign mul_sel  = idle ? mul_in    : mul_q;

   pll_step_word #(
      .MUL_W     (MUL_W),
      .NUM_PAIRS (NUM_PAIRS)
   ) u_word (
      .step_i (step),
      .base_i (base_sel),
      .cfg_i  (cfg_sel),
      .mul_i  (mul_sel),
      .word_o (word)
   );

   pll_lock_timer #(
      .CYCLES (LOCK_CYCLES)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (state_q == ST_BYPOFF),
      .expired_o (expired)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q   <= ST_IDLE;
         cfg_q     <= '0;
         mul_q     <= '0;
         wr_en_q   <= 1'b0;
         wr_data_q <= '0;
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         wr_en_q <= 1'b0;
         done_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  cfg_q     <= cfg_in;
                  mul_q     <= mul_in;
                  wr_en_q   <= 1'b1;
                  wr_data_q <= word;
                  busy_q    <= 1'b1;
                  state_q   <= ST_PWRDN;
               end
            end
            ST_PWRDN, ST_MODE, ST_BYPOFF: begin
               wr_en_q   <= 1'b1;
               wr_data_q <= word;
               state_q   <= (state_q == ST_BYPOFF) ? ST_WAIT : step;
            end
            ST_WAIT: begin
               if (expired) begin
                  busy_q  <= 1'b0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_en_o   = wr_en_q;
   assign wr_addr_o = ADDR_W'(CTRL_ADDR);
   assign wr_data_o = wr_data_q;
   assign busy_o    = busy_q;
   assign done_o    = done_q;

   p_write_in_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_o |-> busy_o);
   p_first_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (wr_en_o && ((wr_data_o & PD_BYP_SET) == PD_BYP_SET)));
   p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   p_done_not_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);
   p_busy_ends_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o);
   p_wait_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !wr_en_o) |=> !wr_en_o);

endmodule

// File: tb/pll_bringup_seq_test.sv
module pll_bringup_seq_test;

   localparam int unsigned ADDR_W = 8;
   localparam int unsigned CADDR  = 8'h2C;
   localparam int unsigned L      = 2 * 100;   // CLK_MHZ * LOCK_US below

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  rx_w = '0, tx_w = '0;
   logic [1:0]  rxl = '0, rxh = '0, txl = '0, txh = '0;
   logic [31:0] rd = '0;
   logic        wr_en, busy, done;
   logic [ADDR_W-1:0] wr_addr;
   logic [31:0] wr_data;

   int checks = 0;
   int fails  = 0;
   int writes = 0;
   int cycles = 0;
   string scen = "reset";

   always #2.5 clk = ~clk;

   pll_bringup_seq #(
      .MODE_W(2), .MUL_W(2), .ADDR_W(ADDR_W), .CTRL_ADDR(CADDR),
      .CLK_MHZ(2), .LOCK_US(100)
   ) uut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .rx_width_i(rx_w), .tx_width_i(tx_w),
      .rx_mul_lo_i(rxl), .rx_mul_hi_i(rxh),
      .tx_mul_lo_i(txl), .tx_mul_hi_i(txh),
      .rd_data_i(rd),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .busy_o(busy), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s (%s): actual %h expected %h", req, scen, act, exp);
      end
   endtask

   // reference model: cycle index t since the accepted start
   int          t = 0;
   logic [31:0] cap = '0;
   bit          mrx = 0, mtx = 0;
   logic [7:0]  mmul = '0;

   always @(posedge clk) begin
      if (!rst_n) t = 0;
      else if (t == 0 || t == L + 4) begin
         if (start) begin
            t    = 1;
            cap  = rd;
            mrx  = (rx_w != 0);   // R3
            mtx  = (tx_w != 0);
            mmul = {txh, txl, rxh, rxl};
         end else t = 0;
      end else t = t + 1;
   end

   function automatic logic [31:0] exp_word(input int step);
      logic [31:0] w;
      w = cap | 32'h0000_F0F0;
      if (step >= 2) begin
         w[24]    = mrx;
         w[25]    = mtx;
         w[23:16] = mmul;
      end
      if (step >= 3) begin
         w[12] = 1'b0; w[14] = 1'b0;
         if (mrx) w[13] = 1'b0;
         if (mtx) w[15] = 1'b0;
      end
      if (step >= 4) begin
         w[4] = 1'b0; w[6] = 1'b0;
         if (mrx) w[5] = 1'b0;
         if (mtx) w[7] = 1'b0;
      end
      return w;
   endfunction

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         bit ew, eb, ed;
         ew = (t >= 1 && t <= 4);
         eb = (t >= 1 && t <= L + 3);
         ed = (t == L + 4);
         if (wr_en) writes++;
         chk(wr_en == ew, "R7", 32'(wr_en), 32'(ew));
         chk(busy == eb,  "R10", 32'(busy), 32'(eb));
         chk(done == ed,  "R8", 32'(done), 32'(ed));
         if (ew) begin
            chk(32'(wr_addr) == CADDR, "R2", 32'(wr_addr), CADDR);
            case (t)
               1: chk(wr_data == exp_word(1), "R2", wr_data, exp_word(1));
               2: chk(wr_data == exp_word(2), "R3 R4", wr_data, exp_word(2));
               3: chk(wr_data == exp_word(3), "R5", wr_data, exp_word(3));
               default: chk(wr_data == exp_word(4), "R6", wr_data, exp_word(4));
            endcase
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run(input string name, input logic [1:0] r, input logic [1:0] x,
                      input logic [7:0] m, input logic [31:0] v);
      scen = name;
      rx_w = r; tx_w = x; {txh, txl, rxh, rxl} = m; rd = v;
      writes = 0;
      pulse_start();
      repeat (L + 8) @(negedge clk);
      chk(writes == 4, "R7", 32'(writes), 32'd4);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !wr_en, "R1", {busy, done, wr_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !wr_en, "R1", {busy, done, wr_en}, 0);

      run("single both", 2'd0, 2'd0, 8'h00, 32'h0000_0000);
      run("rx dual", 2'd1, 2'd0, 8'hE4, 32'hFFFF_FFFF);
      run("tx dual", 2'd0, 2'd3, 8'h1B, 32'h1234_5678);
      run("both dual", 2'd2, 2'd1, 8'hA5, 32'hFFFF_0000);

      // R9: starts while busy and read-data changes are ignored
      scen = "R9 start while busy";
      rx_w = 2'd1; tx_w = 2'd2; {txh, txl, rxh, rxl} = 8'h6C; rd = 32'hA5A5_0F0F;
      writes = 0;
      pulse_start();
      rd = 32'h0000_0000; rx_w = 2'd0; tx_w = 2'd0;
      pulse_start();
      repeat (40) @(negedge clk);
      rd = 32'hFFFF_FFFF;
      pulse_start();
      repeat (L) @(negedge clk);
      chk(writes == 4, "R9", 32'(writes), 32'd4);

      // R10: restart accepted in the done cycle
      scen = "R10 back-to-back";
      rx_w = 2'd3; tx_w = 2'd3; {txh, txl, rxh, rxl} = 8'h3F; rd = 32'h0F0F_F0F0;
      writes = 0;
      pulse_start();
      while (!done) @(negedge clk);
      start = 1'b1; rd = 32'h5555_AAAA;
      @(negedge clk); start = 1'b0;
      repeat (L + 8) @(negedge clk);
      chk(writes == 8, "R10", 32'(writes), 32'd8);
      summary();
   end

   initial begin
      wait (cycles > 100000);
      fails++; checks++;
      $display("FAIL watchdog (%s): actual %0d expected done", scen, cycles);
      summary();
   end

endmodule